// File: doc/BRIEF.md
# Invert-Aware Instruction Decoder

This block is the decode stage of a small 16-bit load/store processor. Each cycle it takes one instruction word and, for the register form of the mode-select instruction, the value already read from the source register. It then produces register indices, a zero-extended immediate, an ALU operation code, memory read and write strobes, a skip request and a write-back enable. It also keeps a single sticky mode bit, the invert flag. While this bit is set, most instructions take their opposite meaning: a load becomes a store, add becomes subtract, a left shift becomes a right shift, NAND becomes AND, NOR becomes OR, and the skip instruction does nothing.

The flag changes only when a mode-select instruction is decoded. The new value applies from the following instruction onward. The decoder also enforces the register conventions. Index 29 reads as zero. Index 30 is the instruction pointer, so a write-back to it is reported as a jump. Indices 29 and 31 are never allowed as write-back targets.

Top module: `instr_decoder`

## Requirements
- R1: After synchronous reset the invert flag output `inv_flag` is 0.
- R2: For register-register forms, `rs_idx` equals instr[10:6] and `rd_idx` equals instr[4:0]. The opcode always sits in instr[15:12].
- R3: Opcodes 0010 and 0011 load a byte constant. `imm` is instr[11:4] zero-extended, `rd_idx` is {0, instr[3:0]}, `use_imm`=1 and `wb_en`=1. `alu_op` is 11 (low byte) for 0010 and 12 (high byte) for 0011, whatever the flag value.
- R4: Opcode 1101 gives `imm` = instr[11:5] zero-extended, `rd_idx` = instr[4:0], `use_imm`=1 and `wb_en`=1. `alu_op` is 9 (add) when the flag is clear and 10 (subtract) when it is set.
- R5: Register ALU forms give `use_imm`=0 and `wb_en`=1. The `alu_op` for flag clear/set is: 0110 → 1/1 (move), 1000 → 2/3 (shift left/right), 1001 → 4/4 (compare), 1010 → 5/6 (NAND/AND), 1011 → 7/8 (NOR/OR), 1100 → 9/10 (add/sub).
- R6: Opcode 0100 with the flag clear gives `mem_rd`=1, `mem_wr`=0 and `wb_en`=1. With the flag set it gives `mem_wr`=1, `mem_rd`=0 and `wb_en`=0. The address comes from register `rs_idx`, and the store data from `rd_idx`.
- R7: Opcode 0001 raises `skip_req` only while the flag is clear. With the flag set it raises nothing. Opcode 0000 raises no strobe in either mode. `alu_op` is 0 for both.
- R8: Opcode 1111 loads the flag with instr[0]. Opcode 1110 sets the flag when `src_val` is nonzero and clears it otherwise. The new value appears on `inv_flag` after the next clock edge, and the mode-select instruction itself is decoded with the old value.
- R9: For opcode 1110 with source index 29, the source counts as zero, so the flag is cleared whatever `src_val` holds.
- R10: The flag keeps its value across every other opcode and across any cycle with `instr_valid` low.
- R11: When an instruction would write back to index 29 or 31, `wb_en` is 0 and `dst_blocked` is 1.
- R12: A permitted write-back to index 30 raises `ip_write`.
- R13: Opcodes 0101 and 0111 raise no strobe and give `alu_op` 0.
- R14: With `instr_valid` low, `wb_en`, `mem_rd`, `mem_wr`, `skip_req`, `ip_write` and `dst_blocked` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 16 | Instruction word |
| src_val | input | DATA_W | Value read from the source register |
| rs_idx | output | 5 | Source register index |
| rd_idx | output | 5 | Destination register index |
| imm | output | DATA_W | Zero-extended immediate |
| use_imm | output | 1 | ALU second operand is `imm` |
| alu_op | output | 4 | ALU operation code |
| inv_flag | output | 1 | Current invert flag |
| mem_rd | output | 1 | Data memory load strobe |
| mem_wr | output | 1 | Data memory store strobe |
| skip_req | output | 1 | Squash the next instruction |
| wb_en | output | 1 | Register write-back enable |
| ip_write | output | 1 | Write-back targets the instruction pointer |
| dst_blocked | output | 1 | Write-back suppressed on a protected index |

## Verification
Each opcode that has two meanings is decoded once with the flag clear and once with it set. This separates the two halves of the mode mapping and would expose a flag that is ignored or inverted. The mode-select instruction is driven with a constant, with nonzero and zero register values, and with source index 29, so a wrong source test, a missing zero-register override or a flag that updates too early shows up. Destination indices 28 to 31 are swept to separate ordinary, jump and protected write-backs. Cycles with `instr_valid` low carrying live opcodes confirm that neither the strobes nor the flag react.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;

    localparam int INSTR_W  = 16;
    localparam int RIDX_W   = 5;
    localparam int ZERO_IDX = 29;
    localparam int IP_IDX   = 30;
    localparam int PIP_IDX  = 31;

    typedef enum logic [3:0] {
        OPC_NOP    = 4'h0,
        OPC_SKIP   = 4'h1,
        OPC_LDI_L  = 4'h2,
        OPC_LDI_H  = 4'h3,
        OPC_MEM    = 4'h4,
        OPC_RSV5   = 4'h5,
        OPC_MOVE   = 4'h6,
        OPC_RSV7   = 4'h7,
        OPC_SHIFT  = 4'h8,
        OPC_CMP    = 4'h9,
        OPC_NAND   = 4'hA,
        OPC_NOR    = 4'hB,
        OPC_ADDR   = 4'hC,
        OPC_ADDI   = 4'hD,
        OPC_MODE_R = 4'hE,
        OPC_MODE_C = 4'hF
    } opc_e;

    typedef enum logic [3:0] {
        ALU_NONE = 4'd0,
        ALU_PASS = 4'd1,
        ALU_SHL  = 4'd2,
        ALU_SHR  = 4'd3,
        ALU_CMP  = 4'd4,
        ALU_NAND = 4'd5,
        ALU_AND  = 4'd6,
        ALU_NOR  = 4'd7,
        ALU_OR   = 4'd8,
        ALU_ADD  = 4'd9,
        ALU_SUB  = 4'd10,
        ALU_LDL  = 4'd11,
        ALU_LDH  = 4'd12
    } alu_e;

    typedef struct packed {
        opc_e              opc;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rd;
        logic              use_imm;
    } fields_t;

    typedef struct packed {
        alu_e alu;
        logic wr_reg;
        logic ld;
        logic st;
        logic skip;
        logic mode_reg;
        logic mode_const;
    } ctrl_t;

    function automatic logic is_protected(input logic [RIDX_W-1:0] idx);
        return (idx == RIDX_W'(ZERO_IDX)) || (idx == RIDX_W'(PIP_IDX));
    endfunction

    function automatic logic is_ip(input logic [RIDX_W-1:0] idx);
        return idx == RIDX_W'(IP_IDX);
    endfunction

endpackage

// File: rtl/dec_fields.sv
module dec_fields
    import instr_dec_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [INSTR_W-1:0] instr,
    output fields_t            fld,
    output logic [DATA_W-1:0]  imm
);

    localparam int BYTE_W = 8;
    localparam int SHORT_W = 7;

    always_comb begin
        fld.opc     = opc_e'(instr[15:12]);
        fld.rs      = instr[10:6];
        fld.rd      = instr[4:0];
        fld.use_imm = 1'b0;
        imm         = '0;
        case (fld.opc)
            OPC_LDI_L, OPC_LDI_H: begin
                fld.rs             = '0;
                fld.rd             = {1'b0, instr[3:0]};
                fld.use_imm        = 1'b1;
                imm[BYTE_W-1:0]    = instr[11:4];
            end
            OPC_ADDI: begin
                fld.rs             = '0;
                fld.use_imm        = 1'b1;
                imm[SHORT_W-1:0]   = instr[11:5];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dec_ctrl.sv
module dec_ctrl
    import instr_dec_pkg::*;
(
    input  opc_e  opc,
    input  logic  inv,
    output ctrl_t ctl
);

    always_comb begin
        ctl = '{alu: ALU_NONE, wr_reg: 1'b0, ld: 1'b0, st: 1'b0,
                skip: 1'b0, mode_reg: 1'b0, mode_const: 1'b0};
        case (opc)
            OPC_SKIP:   ctl.skip = ~inv;
            OPC_LDI_L:  begin ctl.alu = ALU_LDL; ctl.wr_reg = 1'b1; end
            OPC_LDI_H:  begin ctl.alu = ALU_LDH; ctl.wr_reg = 1'b1; end
            OPC_MEM: begin
                ctl.ld     = ~inv;
                ctl.st     = inv;
                ctl.wr_reg = ~inv;
            end
            OPC_MOVE:   begin ctl.alu = ALU_PASS; ctl.wr_reg = 1'b1; end
            OPC_SHIFT:  begin ctl.alu = inv ? ALU_SHR : ALU_SHL; ctl.wr_reg = 1'b1; end
            OPC_CMP:    begin ctl.alu = ALU_CMP; ctl.wr_reg = 1'b1; end
            OPC_NAND:   begin ctl.alu = inv ? ALU_AND : ALU_NAND; ctl.wr_reg = 1'b1; end
            OPC_NOR:    begin ctl.alu = inv ? ALU_OR : ALU_NOR; ctl.wr_reg = 1'b1; end
            OPC_ADDR, OPC_ADDI: begin
                ctl.alu    = inv ? ALU_SUB : ALU_ADD;
                ctl.wr_reg = 1'b1;
            end
            OPC_MODE_R: ctl.mode_reg   = 1'b1;
            OPC_MODE_C: ctl.mode_const = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/inv_state.sv
module inv_state (
    input  logic clk,
    input  logic rst,
    input  logic valid,
    input  logic mode_reg,
    input  logic mode_const,
    input  logic const_bit,
    input  logic src_nonzero,
    output logic inv_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            inv_q <= 1'b0;
        end else if (valid && mode_const) begin
            inv_q <= const_bit;
        end else if (valid && mode_reg) begin
            inv_q <= src_nonzero;
        end
    end

endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
    import instr_dec_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [15:0]       instr,
    input  logic [DATA_W-1:0] src_val,
    output logic [4:0]        rs_idx,
    output logic [4:0]        rd_idx,
    output logic [DATA_W-1:0] imm,
    output logic              use_imm,
    output logic [3:0]        alu_op,
    output logic              inv_flag,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              skip_req,
    output logic              wb_en,
    output logic              ip_write,
    output logic              dst_blocked
);

    fields_t fld;
    ctrl_t   ctl;
    logic    inv_q;
    logic    src_nz;
    logic    wr_req;

    dec_fields #(.DATA_W(DATA_W)) u_fields (
        .instr (instr),
        .fld   (fld),
        .imm   (imm)
    );

    dec_ctrl u_ctrl (
        .opc (fld.opc),
        .inv (inv_q),
        .ctl (ctl)
    );

    // the zero register overrides whatever value was read for it
    assign src_nz = (fld.rs == RIDX_W'(ZERO_IDX)) ? 1'b0 : (|src_val);

    inv_state u_inv (
        .clk         (clk),
        .rst         (rst),
        .valid       (instr_valid),
        .mode_reg    (ctl.mode_reg),
        .mode_const  (ctl.mode_const),
        .const_bit   (instr[0]),
        .src_nonzero (src_nz),
        .inv_q       (inv_q)
    );

    assign wr_req      = instr_valid & ctl.wr_reg;
    assign dst_blocked = wr_req & is_protected(fld.rd);
    assign wb_en       = wr_req & ~is_protected(fld.rd);
    assign ip_write    = wb_en & is_ip(fld.rd);
    assign mem_rd      = instr_valid & ctl.ld;
    assign mem_wr      = instr_valid & ctl.st;
    assign skip_req    = instr_valid & ctl.skip;
    assign rs_idx      = fld.rs;
    assign rd_idx      = fld.rd;
    assign use_imm     = fld.use_imm;
    assign alu_op      = ctl.alu;
    assign inv_flag    = inv_q;

endmodule

// File: rtl/instr_dec_checker.sv
module instr_dec_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              instr_valid,
    input logic [15:0]       instr,
    input logic [DATA_W-1:0] src_val,
    input logic [4:0]        rd_idx,
    input logic              inv_flag,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              skip_req,
    input logic              wb_en,
    input logic              ip_write
);

    logic mode_op;
    assign mode_op = instr_valid && (instr[15:13] == 3'b111);

    p_mode_const_r8: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr[15:12] == 4'hF) |=> (inv_flag == $past(instr[0])));

    p_mode_zero_src_r9: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr[15:12] == 4'hE && instr[10:6] == 5'd29) |=> !inv_flag);

    p_mode_reg_r8: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr[15:12] == 4'hE && instr[10:6] != 5'd29)
        |=> (inv_flag == ($past(src_val) != '0)));

    p_flag_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !mode_op |=> $stable(inv_flag));

    p_ld_st_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    p_store_no_wb_r6: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (!wb_en && inv_flag));

    p_protected_r11: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (rd_idx != 5'd29 && rd_idx != 5'd31));

    p_skip_mode_r7: assert property (@(posedge clk) disable iff (rst)
        skip_req |-> !inv_flag);

    p_jump_r12: assert property (@(posedge clk) disable iff (rst)
        ip_write |-> (wb_en && rd_idx == 5'd30));

    p_idle_r14: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |-> !(wb_en || mem_rd || mem_wr || skip_req || ip_write));

endmodule

bind instr_decoder instr_dec_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr       (instr),
    .src_val     (src_val),
    .rd_idx      (rd_idx),
    .inv_flag    (inv_flag),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .skip_req    (skip_req),
    .wb_en       (wb_en),
    .ip_write    (ip_write)
);

// File: tb/instr_decoder_tb_top.sv
`timescale 1ns/1ps
module instr_decoder_tb_top;

    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst;
    logic              instr_valid;
    logic [15:0]       instr;
    logic [DATA_W-1:0] src_val;
    logic [4:0]        rs_idx, rd_idx;
    logic [DATA_W-1:0] imm;
    logic              use_imm;
    logic [3:0]        alu_op;
    logic              inv_flag, mem_rd, mem_wr, skip_req, wb_en, ip_write, dst_blocked;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    instr_decoder #(.DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .src_val(src_val), .rs_idx(rs_idx), .rd_idx(rd_idx), .imm(imm),
        .use_imm(use_imm), .alu_op(alu_op), .inv_flag(inv_flag),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .skip_req(skip_req),
        .wb_en(wb_en), .ip_write(ip_write), .dst_blocked(dst_blocked)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] rr(input logic [3:0] op, input logic [4:0] s, input logic [4:0] d);
        return {op, 1'b0, s, 1'b0, d};
    endfunction

    // drive at the falling edge, let combinational outputs settle
    task automatic apply(input logic [15:0] w, input logic [DATA_W-1:0] sv, input logic v);
        @(negedge clk);
        instr = w; src_val = sv; instr_valid = v;
        #1;
    endtask

    task automatic set_flag(input logic b);
        apply({4'hF, 11'd0, b}, '0, 1'b1);
    endtask

    task automatic strobes(input string req, input logic [5:0] exp);
        chk(req, {26'd0, wb_en, mem_rd, mem_wr, skip_req, ip_write, dst_blocked}, {26'd0, exp});
    endtask

    task automatic t_reset;
        rst = 1'b1; instr_valid = 1'b0; instr = '0; src_val = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        apply(16'h0000, '0, 1'b0);
        chk("R1 flag after reset", inv_flag, 0);
    endtask

    task automatic t_fields;
        apply(rr(4'h6, 5'd21, 5'd10), '0, 1'b1);
        chk("R2 rs", rs_idx, 21);
        chk("R2 rd", rd_idx, 10);
        apply(rr(4'hA, 5'd3, 5'd17), '0, 1'b1);
        chk("R2 rs", rs_idx, 3);
        chk("R2 rd", rd_idx, 17);
    endtask

    task automatic t_ldi;
        for (int f = 0; f < 2; f++) begin
            set_flag(f[0]);
            apply({4'h2, 8'hA5, 4'd7}, '0, 1'b1);
            chk("R3 imm low", imm, 16'h00A5);
            chk("R3 rd low", rd_idx, 7);
            chk("R3 op low", alu_op, 11);
            chk("R3 use_imm", use_imm, 1);
            chk("R3 wb", wb_en, 1);
            apply({4'h3, 8'hFF, 4'd15}, '0, 1'b1);
            chk("R3 imm high", imm, 16'h00FF);
            chk("R3 rd high", rd_idx, 15);
            chk("R3 op high", alu_op, 12);
        end
        set_flag(1'b0);
    endtask

    task automatic t_addc;
        apply({4'hD, 7'h7F, 5'd20}, '0, 1'b1);
        chk("R4 imm", imm, 16'h007F);
        chk("R4 rd", rd_idx, 20);
        chk("R4 add", alu_op, 9);
        chk("R4 use_imm", use_imm, 1);
        chk("R4 wb", wb_en, 1);
        set_flag(1'b1);
        apply({4'hD, 7'h15, 5'd2}, '0, 1'b1);
        chk("R4 imm", imm, 16'h0015);
        chk("R4 sub", alu_op, 10);
        set_flag(1'b0);
    endtask

    function automatic logic [3:0] exp_alu(input logic [3:0] op, input logic f);
        case (op)
            4'h6: return 4'd1;
            4'h8: return f ? 4'd3 : 4'd2;
            4'h9: return 4'd4;
            4'hA: return f ? 4'd6 : 4'd5;
            4'hB: return f ? 4'd8 : 4'd7;
            default: return f ? 4'd10 : 4'd9;
        endcase
    endfunction

    task automatic t_regalu;
        logic [3:0] ops [6];
        ops = '{4'h6, 4'h8, 4'h9, 4'hA, 4'hB, 4'hC};
        for (int f = 0; f < 2; f++) begin
            set_flag(f[0]);
            for (int i = 0; i < 6; i++) begin
                apply(rr(ops[i], 5'd4, 5'd9), '0, 1'b1);
                chk($sformatf("R5 op %h flag %0d", ops[i], f), alu_op, exp_alu(ops[i], f[0]));
                chk("R5 use_imm", use_imm, 0);
                chk("R5 wb", wb_en, 1);
            end
        end
        set_flag(1'b0);
    endtask

    task automatic t_ldst;
        apply(rr(4'h4, 5'd5, 5'd6), '0, 1'b1);
        strobes("R6 load", 6'b110000);
        set_flag(1'b1);
        apply(rr(4'h4, 5'd5, 5'd6), '0, 1'b1);
        strobes("R6 store", 6'b001000);
        chk("R6 addr idx", rs_idx, 5);
        set_flag(1'b0);
    endtask

    task automatic t_skip_nop;
        apply(16'h1000, '0, 1'b1);
        strobes("R7 skip", 6'b000100);
        chk("R7 skip op", alu_op, 0);
        apply(16'h0000, '0, 1'b1);
        strobes("R7 nop", 6'b000000);
        set_flag(1'b1);
        apply(16'h1000, '0, 1'b1);
        strobes("R7 skip inverted", 6'b000000);
        apply(16'h0000, '0, 1'b1);
        strobes("R7 nop inverted", 6'b000000);
        set_flag(1'b0);
    endtask

    task automatic t_mode;
        apply(16'hF001, '0, 1'b1);
        chk("R8 old flag during mode op", inv_flag, 0);
        apply(16'h0000, '0, 1'b0);
        chk("R8 const set", inv_flag, 1);
        apply(16'hF000, '0, 1'b1);
        chk("R8 old flag during clear", inv_flag, 1);
        apply(16'h0000, '0, 1'b0);
        chk("R8 const clear", inv_flag, 0);
        apply(rr(4'hE, 5'd3, 5'd0), 16'h0100, 1'b1);
        apply(16'h0000, '0, 1'b0);
        chk("R8 reg nonzero", inv_flag, 1);
        apply(rr(4'hE, 5'd3, 5'd0), 16'h0000, 1'b1);
        apply(16'h0000, '0, 1'b0);
        chk("R8 reg zero", inv_flag, 0);
    endtask

    task automatic t_zero_src;
        set_flag(1'b1);
        apply(rr(4'hE, 5'd29, 5'd0), 16'hFFFF, 1'b1);
        apply(16'h0000, '0, 1'b0);
        chk("R9 zero register source", inv_flag, 0);
    endtask

    task automatic t_hold;
        set_flag(1'b1);
        apply(rr(4'hC, 5'd1, 5'd2), '0, 1'b1);
        apply(16'h1000, '0, 1'b1);
        apply(rr(4'h4, 5'd1, 5'd2), '0, 1'b1);
        apply(16'hF000, '0, 1'b0);
        apply(rr(4'hE, 5'd1, 5'd0), '0, 1'b0);
        apply(16'h0000, '0, 1'b0);
        chk("R10 flag held", inv_flag, 1);
        set_flag(1'b0);
        apply(16'hF001, '0, 1'b0);
        apply(16'h0000, '0, 1'b0);
        chk("R10 flag held clear", inv_flag, 0);
    endtask

    task automatic t_protect;
        for (int d = 28; d < 32; d++) begin
            apply(rr(4'h6, 5'd0, 5'(d)), '0, 1'b1);
            strobes($sformatf("R11 R12 move to %0d", d),
                    (d == 29 || d == 31) ? 6'b000001 :
                    (d == 30) ? 6'b100010 : 6'b100000);
        end
        apply(rr(4'h4, 5'd2, 5'd31), '0, 1'b1);
        chk("R11 load to 31 blocked", {wb_en, dst_blocked}, 2'b01);
        apply(rr(4'hC, 5'd2, 5'd30), '0, 1'b1);
        chk("R12 add to ip", ip_write, 1);
    endtask

    task automatic t_reserved;
        for (int f = 0; f < 2; f++) begin
            set_flag(f[0]);
            apply(rr(4'h5, 5'd1, 5'd2), '0, 1'b1);
            strobes("R13 opcode 5", 6'b000000);
            chk("R13 opcode 5 op", alu_op, 0);
            apply(rr(4'h7, 5'd1, 5'd2), '0, 1'b1);
            strobes("R13 opcode 7", 6'b000000);
            chk("R13 opcode 7 op", alu_op, 0);
        end
        set_flag(1'b0);
    endtask

    task automatic t_idle;
        apply(rr(4'h4, 5'd1, 5'd30), '0, 1'b0);
        strobes("R14 idle load", 6'b000000);
        apply(16'h1000, '0, 1'b0);
        strobes("R14 idle skip", 6'b000000);
        apply(rr(4'h6, 5'd1, 5'd29), '0, 1'b0);
        strobes("R14 idle blocked", 6'b000000);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_fields();
        t_ldi();
        t_addc();
        t_regalu();
        t_ldst();
        t_skip_nop();
        t_mode();
        t_zero_src();
        t_hold();
        t_protect();
        t_reserved();
        t_idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule